// File: doc/BRIEF.md
# Programmable Down-Counter Timer

A register-mapped timer peripheral that counts down on a clock-enable tick, divided first by a selectable prescaler. Software programs a reload limit, picks a counter width of 16 or 32 bits, and chooses one of three behaviours: free-running (wraps to all ones of the selected width), periodic (wraps to the programmed limit) or one-shot (halts at zero). Each time a counting step leaves the counter at zero, a sticky raw interrupt flag is set. The level interrupt output and a masked status register both show that flag gated by an enable bit. The flag is cleared by writing any value to a dedicated clear location.

The bus uses word addresses with a single-cycle write strobe. Read data is combinational on the address. The limit can be written in two ways. The immediate path reloads the counter at once. The background path only replaces the value used at the next wrap.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable set; counting, periodic, one-shot and wide clear; divide by 1). The count, the limit and the raw flag read 0, and `irq_out` is low.
- R2: A write to word offset 0 sets the limit and loads it into the counter in the same edge. It overrides a counting step that falls in that cycle. Offsets 0 and 6 both read back the limit.
- R3: A write to offset 6 changes the limit without touching the live count. The new limit is used at the next wrap.
- R4: Each prescaled step decrements the count by one, within the width picked by control bit 1 (1 = 32 bits, 0 = 16 bits). In free-running mode (control bit 6 = 0), a step from zero wraps to 0xFFFF or 0xFFFFFFFF. Offset 1 reads the live count.
- R5: In periodic mode (control bit 6 = 1), a step from zero reloads the limit.
- R6: In one-shot mode (control bit 0 = 1), the counter stays at zero once it gets there, and takes no further steps until offset 0 is written.
- R7: Control bits [3:2] set the prescale divide: 00 gives 1, 01 gives 16, 10 gives 256, and 11 gives 1. Any write to the control register (offset 2) restarts the prescaler.
- R8: A step that leaves the count at zero sets the raw flag, which reads at bit 0 of offset 4. Any write to offset 3 clears it. If an expiry and a clear write fall in the same cycle, the flag stays set.
- R9: `irq_out` and bit 0 of offset 5 both equal the raw flag ANDed with control bit 5. Offset 5 reads 0 while that bit is clear.
- R10: Writes to offset 1 leave the count unchanged. Offset 7 reads 0, and writes to it change no register.
- R11: While control bit 7 is clear, ticks do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count clock enable, fed to the prescaler |
| bus_addr | input | 3 | Word offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
The counter's expiry and a software write to the clear location can land on the same edge. A correct design must keep the flag set, because the clear would otherwise erase a new event. The bench provokes this by holding the tick and a write to offset 3 together in the cycle when the count steps from 1 to 0. It then reads the raw status, expecting 1, and issues a second clear alone, expecting 0. In the same way, an immediate limit write is driven in a tick cycle, and the count must read the written value rather than the value after a decrement.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int DATA_W   = 32;
    localparam int NARROW_W = 16;
    localparam int ADDR_W   = 3;
    localparam int PRE_W    = 8;
    localparam int CTRL_W   = 8;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] div;
        logic       wide;
        logic       single;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{run: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                     spare: 1'b0, div: 2'b00, wide: 1'b0,
                                     single: 1'b0};

    typedef enum logic [ADDR_W-1:0] {
        OFF_LOAD   = 3'd0,
        OFF_VALUE  = 3'd1,
        OFF_CTRL   = 3'd2,
        OFF_CLR    = 3'd3,
        OFF_RAW    = 3'd4,
        OFF_MASKED = 3'd5,
        OFF_BGLOAD = 3'd6
    } off_e;

    function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
        case (sel)
            2'b01:   return PRE_W'(15);
            2'b10:   return PRE_W'(255);
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic wide);
        return wide ? {DATA_W{1'b1}} : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
    import cdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       run,
    input  logic [1:0] div_sel,
    input  logic       ctrl_wr,
    output logic       step
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    assign last = pre_last(div_sel);
    assign step = tick_en && run && !ctrl_wr && (pre_q == last);

    always_ff @(posedge clk) begin
        if (rst || ctrl_wr) begin
            pre_q <= '0;
        end else if (tick_en && run) begin
            pre_q <= (pre_q == last) ? '0 : pre_q + 1'b1;
        end
    end

    // R7
    pre_restart_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (pre_q == '0));

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] limit,
    input  logic              wide,
    input  logic              periodic,
    input  logic              single,
    output logic [DATA_W-1:0] cnt_val,
    output logic              expire
);
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] reload;
    logic [DATA_W-1:0] step_next;
    logic              halted;
    logic              eff_step;

    assign mask      = width_mask(wide);
    assign cnt_val   = cnt_q & mask;
    assign reload    = (periodic ? limit : {DATA_W{1'b1}}) & mask;
    assign halted    = single && (cnt_val == '0);
    assign eff_step  = step && !halted;
    assign step_next = (cnt_val == '0) ? reload : ((cnt_val - 1'b1) & mask);
    assign expire    = eff_step && !load_wr && (step_next == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_wr) begin
            cnt_q <= load_val;
        end else if (eff_step) begin
            cnt_q <= step_next;
        end
    end

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !load_wr) |=> $stable(cnt_q));

    // R6
    single_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (single && cnt_val == '0 && !load_wr) |=> $stable(cnt_q));

    // R4
    decrement_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load_wr && cnt_val > 1) |=> (cnt_val == $past(cnt_val) - 1'b1));

endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    input  logic [DATA_W-1:0] cnt_val,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] limit,
    output logic              raw,
    output logic              ctrl_wr,
    output logic              load_wr,
    output logic [DATA_W-1:0] rdata
);
    off_e off;
    logic bg_wr;
    logic clr_wr;

    assign off     = off_e'(addr);
    assign load_wr = we && (off == OFF_LOAD);
    assign bg_wr   = we && (off == OFF_BGLOAD);
    assign ctrl_wr = we && (off == OFF_CTRL);
    assign clr_wr  = we && (off == OFF_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= CTRL_RESET;
            limit <= '0;
            raw   <= 1'b0;
        end else begin
            if (ctrl_wr)         ctrl  <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (load_wr || bg_wr) limit <= wdata;
            if (expire)          raw   <= 1'b1;
            else if (clr_wr)     raw   <= 1'b0;
        end
    end

    always_comb begin
        case (off)
            OFF_LOAD, OFF_BGLOAD: rdata = limit;
            OFF_VALUE:            rdata = cnt_val;
            OFF_CTRL:             rdata = DATA_W'(ctrl);
            OFF_RAW:              rdata = DATA_W'(raw);
            OFF_MASKED:           rdata = DATA_W'(raw && ctrl.irq_en);
            default:              rdata = '0;
        endcase
    end

    // R8
    expire_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> raw);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !expire) |=> !raw);

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] limit;
    logic [DATA_W-1:0] cnt_val;
    logic              raw;
    logic              ctrl_wr;
    logic              load_wr;
    logic              step;
    logic              expire;

    cdt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .expire  (expire),
        .cnt_val (cnt_val),
        .ctrl    (ctrl),
        .limit   (limit),
        .raw     (raw),
        .ctrl_wr (ctrl_wr),
        .load_wr (load_wr),
        .rdata   (bus_rdata)
    );

    cdt_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .run     (ctrl.run),
        .div_sel (ctrl.div),
        .ctrl_wr (ctrl_wr),
        .step    (step)
    );

    cdt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .load_wr  (load_wr),
        .load_val (bus_wdata),
        .limit    (limit),
        .wide     (ctrl.wide),
        .periodic (ctrl.periodic),
        .single   (ctrl.single),
        .cnt_val  (cnt_val),
        .expire   (expire)
    );

    assign irq_out = raw && ctrl.irq_en;

endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cdt_timer u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s: offset %0d read %h expected %h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic irq_chk(input logic exp, input string req);
        @(negedge clk);
        #1;
        checks++;
        if (irq_out !== exp) begin
            fails++;
            $display("FAIL %s: irq_out %b expected %b", req, irq_out, exp);
        end
    endtask

    task automatic t_reset;
        rd_chk(2, 32'h20, "R1");
        rd_chk(1, 32'h0, "R1");
        rd_chk(0, 32'h0, "R1");
        rd_chk(4, 32'h0, "R1");
        irq_chk(1'b0, "R1");
    endtask

    task automatic t_load;
        wr(2, 32'hA2);
        wr(0, 32'd10);
        rd_chk(1, 32'd10, "R2");
        rd_chk(6, 32'd10, "R2");
        ticks(3);
        rd_chk(1, 32'd7, "R4");
    endtask

    task automatic t_free;
        wr(2, 32'hA0);
        wr(0, 32'd2);
        ticks(2);
        rd_chk(1, 32'd0, "R4");
        rd_chk(4, 32'd1, "R8");
        irq_chk(1'b1, "R9");
        ticks(1);
        rd_chk(1, 32'hFFFF, "R4");
        wr(3, 32'd0);
        rd_chk(4, 32'd0, "R8");
        wr(2, 32'hA2);
        wr(0, 32'd1);
        ticks(2);
        rd_chk(1, 32'hFFFF_FFFF, "R4");
        wr(3, 32'd0);
    endtask

    task automatic t_periodic;
        wr(2, 32'hE2);
        wr(0, 32'd3);
        ticks(4);
        rd_chk(1, 32'd3, "R5");
        ticks(1);
        wr(6, 32'd5);
        rd_chk(1, 32'd2, "R3");
        rd_chk(0, 32'd5, "R3");
        ticks(2);
        rd_chk(1, 32'd0, "R3");
        ticks(1);
        rd_chk(1, 32'd5, "R3");
        wr(3, 32'd0);
    endtask

    task automatic t_single;
        wr(2, 32'hA3);
        wr(0, 32'd2);
        ticks(5);
        rd_chk(1, 32'd0, "R6");
        rd_chk(4, 32'd1, "R6");
        wr(0, 32'd4);
        rd_chk(1, 32'd4, "R6");
        ticks(1);
        rd_chk(1, 32'd3, "R6");
        wr(3, 32'd0);
    endtask

    task automatic t_prescale;
        wr(2, 32'hA6);
        wr(0, 32'd100);
        ticks(15);
        rd_chk(1, 32'd100, "R7");
        ticks(1);
        rd_chk(1, 32'd99, "R7");
        wr(2, 32'hAA);
        wr(0, 32'd100);
        ticks(255);
        rd_chk(1, 32'd100, "R7");
        ticks(1);
        rd_chk(1, 32'd99, "R7");
        wr(2, 32'hAE);
        wr(0, 32'd100);
        ticks(1);
        rd_chk(1, 32'd99, "R7");
        wr(2, 32'hA6);
        wr(0, 32'd50);
        ticks(10);
        wr(2, 32'hA6);
        ticks(15);
        rd_chk(1, 32'd50, "R7");
        ticks(1);
        rd_chk(1, 32'd49, "R7");
    endtask

    task automatic t_mask;
        wr(2, 32'h82);
        wr(0, 32'd1);
        ticks(1);
        rd_chk(4, 32'd1, "R9");
        rd_chk(5, 32'd0, "R9");
        irq_chk(1'b0, "R9");
        wr(2, 32'hA2);
        rd_chk(5, 32'd1, "R9");
        irq_chk(1'b1, "R9");
        wr(3, 32'd0);
        irq_chk(1'b0, "R8");
    endtask

    task automatic t_ignored;
        wr(2, 32'h22);
        wr(0, 32'd20);
        wr(1, 32'h1234);
        rd_chk(1, 32'd20, "R10");
        wr(7, 32'hFF);
        rd_chk(7, 32'd0, "R10");
        rd_chk(2, 32'h22, "R10");
        rd_chk(0, 32'd20, "R10");
        ticks(5);
        rd_chk(1, 32'd20, "R11");
    endtask

    task automatic t_collide;
        wr(2, 32'hA2);
        wr(0, 32'd1);
        @(negedge clk);
        tick_en = 1'b1; bus_addr = 3; bus_we = 1'b1; bus_wdata = '0;
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0;
        rd_chk(4, 32'd1, "R8");
        wr(3, 32'd0);
        rd_chk(4, 32'd0, "R8");
        wr(0, 32'd9);
        @(negedge clk);
        tick_en = 1'b1; bus_addr = 0; bus_we = 1'b1; bus_wdata = 32'd7;
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0;
        rd_chk(1, 32'd7, "R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_free();
        t_periodic();
        t_single();
        t_prescale();
        t_mask();
        t_ignored();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule